// File: doc/BRIEF.md
# Receive Queue Index Manager

This block keeps the bookkeeping for a small receive message queue of three slots. The slots hold received messages in storage outside the block; only the write pointer, read pointer, occupancy count, status bits and event flags live here. A receive handler asks once per message to store it. The block either grants the store or refuses it, and the slot that is written is the one the write pointer shows while the request is held. When the queue is full, the outcome depends on a mode bit. In hold-off mode the new message is dropped and a loss is recorded. In replace mode the oldest message is discarded to make room.

The host drains the queue by reading messages and then writing the slot number of the last one it consumed. The read pointer jumps to the slot after that one, and the occupancy count shrinks by the number of slots released. The host may release any number of slots this way in a single write. Three sticky event flags (new message, became full, message lost) are held until the host clears them. A lost status output follows the lost flag.

Top module: `rxq_index_mgr`

## Requirements
- R1: After reset, putIdx, getIdx and fillLevel are 0, all three event flags and both status outputs are 0, and modeOverwrite is 0 (hold-off mode).
- R2: A store request (storeReq=1, storeAbort=0) to a queue that is not full advances putIdx by one modulo 3 (so 2 wraps to 0) and raises fillLevel by one. It sets irqNew, and all of this is visible one cycle after the request.
- R3: An acknowledge write (ackWrEn=1) with ackIdx=A, where A is an occupied slot, sets getIdx to (A+1) modulo 3. It lowers fillLevel by the number of slots from getIdx up to and including A. Both changes take one cycle.
- R4: An acknowledge write whose ackIdx is not an occupied slot is ignored. This includes any value of 3 or more. getIdx and fillLevel stay unchanged.
- R5: fullSt is 1 exactly when fillLevel is 3. irqFull is set in the cycle in which fillLevel changes from a value below 3 to 3.
- R6: In hold-off mode, a store request to a full queue leaves putIdx, getIdx and fillLevel unchanged and sets irqLost. lostSt equals irqLost.
- R7: In replace mode, a store request to a full queue advances both putIdx and getIdx by one modulo 3. fillLevel stays at 3, irqNew is set and irqLost is not set.
- R8: modeOverwrite loads modeWrVal (1 = replace, 0 = hold-off) on modeWrEn only when cfgInit=1 and cfgChangeEn=1 in the same cycle. Otherwise the write is ignored.
- R9: A store request with storeAbort=1, which marks a failed message storage access, changes no pointer, no count and no flag.
- R10: clrNew, clrFull and clrLost each clear their flag one cycle later, and lostSt clears together with irqLost. A flag that is set and cleared in the same cycle ends up set.
- R11: When a store and an acknowledge arrive in the same cycle, the acknowledge is applied first. A slot it frees is available to the store, so the store is not treated as a store to a full queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgInit | input | 1 | Controller held in initialization |
| cfgChangeEn | input | 1 | Configuration changes allowed |
| modeWrEn | input | 1 | Write strobe for the full-queue mode |
| modeWrVal | input | 1 | Mode value: 1 replace, 0 hold-off |
| storeReq | input | 1 | Receive handler asks to store a message |
| storeAbort | input | 1 | Storage access failed; store is void |
| ackWrEn | input | 1 | Host acknowledge write strobe |
| ackIdx | input | 2 | Slot number of the last message read |
| clrNew | input | 1 | Clear new-message flag |
| clrFull | input | 1 | Clear became-full flag |
| clrLost | input | 1 | Clear message-lost flag |
| putIdx | output | 2 | Write pointer (slot for the next store) |
| getIdx | output | 2 | Read pointer (oldest occupied slot) |
| fillLevel | output | 2 | Number of occupied slots, 0 to 3 |
| fullSt | output | 1 | Queue full status |
| lostSt | output | 1 | Message-lost status, follows irqLost |
| irqNew | output | 1 | New-message event flag |
| irqFull | output | 1 | Became-full event flag |
| irqLost | output | 1 | Message-lost event flag |
| modeOverwrite | output | 1 | Current mode: 1 replace, 0 hold-off |

## Verification
The hardest situation to reach is a store and an acknowledge in the same cycle while the queue is full in replace mode. Here the acknowledge must free a slot before the store is judged, so the read pointer moves to the acknowledged slot plus one and not by one. To reach it, the stimulus first unlocks the mode write by holding both configuration inputs high and selects replace mode. It then fills all three slots and performs one replacing store, so the pointers sit at a non-zero offset. Only then does it issue the combined store and acknowledge. A wrapped write pointer and an acknowledge of an unoccupied slot are reached earlier in the vector table, the latter by acknowledging just behind the read pointer after a partial release.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Single-bit strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic advPut;         // write pointer moves by one slot
    logic advGetOnStore;  // read pointer moves by one (replace on full)
    logic jumpGet;        // read pointer loads the acknowledge target
    logic setNew;
    logic setFull;
    logic setLost;
    logic loadMode;
  } rxqStrobeT;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            cfgInit,
  input  logic            cfgChangeEn,
  input  logic            modeWrEn,
  input  logic            storeReq,
  input  logic            storeAbort,
  input  logic            ackWrEn,
  input  logic [IDXW-1:0] ackIdx,
  input  logic [IDXW-1:0] getIdx,
  input  logic [CNTW-1:0] fillLevel,
  input  logic            modeOverwrite,
  output rxqStrobeT       strb,
  output logic [IDXW-1:0] getTarget,
  output logic [CNTW-1:0] relCnt
);
  localparam logic [IDXW:0]   DEPTH_W = (IDXW + 1)'(DEPTH);
  localparam logic [CNTW-1:0] FULL_C  = CNTW'(DEPTH);

  function automatic logic [IDXW-1:0] incIdx(input logic [IDXW-1:0] v);
    return (int'(v) == DEPTH - 1) ? '0 : v + 1'b1;
  endfunction

  logic [IDXW:0]   offs;
  logic            idxInRange;
  logic            ackValid;
  logic [CNTW-1:0] fillAfterAck;
  logic [CNTW-1:0] fillNext;
  logic            storeOk;
  logic            fullNow;

  // Distance from the read pointer to the acknowledged slot, modulo DEPTH.
  always_comb begin
    if ({1'b0, ackIdx} >= {1'b0, getIdx})
      offs = {1'b0, ackIdx} - {1'b0, getIdx};
    else
      offs = {1'b0, ackIdx} + DEPTH_W - {1'b0, getIdx};
  end

  assign idxInRange   = ({1'b0, ackIdx} < DEPTH_W);
  assign ackValid     = ackWrEn && idxInRange && (int'(offs) < int'(fillLevel));
  assign relCnt       = ackValid ? CNTW'(int'(offs) + 1) : '0;
  assign getTarget    = incIdx(ackIdx);
  assign fillAfterAck = fillLevel - relCnt;
  assign fullNow      = (fillAfterAck == FULL_C);
  assign storeOk      = storeReq && !storeAbort;

  always_comb begin
    strb               = '0;
    strb.jumpGet       = ackValid;
    strb.advPut        = storeOk && (!fullNow || modeOverwrite);
    strb.advGetOnStore = storeOk && fullNow && modeOverwrite;
    strb.setNew        = strb.advPut;
    strb.setLost       = storeOk && fullNow && !modeOverwrite;
    strb.loadMode      = modeWrEn && cfgInit && cfgChangeEn;
    fillNext           = fillAfterAck +
                         CNTW'(strb.advPut && !strb.advGetOnStore);
    strb.setFull       = (fillNext == FULL_C) && (fillLevel != FULL_C);
  end
endmodule

// File: rtl/rxq_dp.sv
module rxq_dp
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  rxqStrobeT       strb,
  input  logic [IDXW-1:0] getTarget,
  input  logic [CNTW-1:0] relCnt,
  input  logic            modeWrVal,
  input  logic            clrNew,
  input  logic            clrFull,
  input  logic            clrLost,
  output logic [IDXW-1:0] putIdx,
  output logic [IDXW-1:0] getIdx,
  output logic [CNTW-1:0] fillLevel,
  output logic            irqNew,
  output logic            irqFull,
  output logic            irqLost,
  output logic            modeOverwrite
);
  function automatic logic [IDXW-1:0] incIdx(input logic [IDXW-1:0] v);
    return (int'(v) == DEPTH - 1) ? '0 : v + 1'b1;
  endfunction

  logic [IDXW-1:0] getMid;
  logic [IDXW-1:0] getNext;
  logic [CNTW-1:0] fillNext;

  always_comb begin
    getMid   = strb.jumpGet ? getTarget : getIdx;
    getNext  = strb.advGetOnStore ? incIdx(getMid) : getMid;
    fillNext = fillLevel - relCnt +
               CNTW'(strb.advPut && !strb.advGetOnStore);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      putIdx        <= '0;
      getIdx        <= '0;
      fillLevel     <= '0;
      irqNew        <= 1'b0;
      irqFull       <= 1'b0;
      irqLost       <= 1'b0;
      modeOverwrite <= 1'b0;
    end else begin
      if (strb.advPut) putIdx <= incIdx(putIdx);
      getIdx    <= getNext;
      fillLevel <= fillNext;
      if (strb.loadMode) modeOverwrite <= modeWrVal;
      if (strb.setNew)       irqNew  <= 1'b1;
      else if (clrNew)       irqNew  <= 1'b0;
      if (strb.setFull)      irqFull <= 1'b1;
      else if (clrFull)      irqFull <= 1'b0;
      if (strb.setLost)      irqLost <= 1'b1;
      else if (clrLost)      irqLost <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_index_mgr.sv
module rxq_index_mgr
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgInit,
  input  logic            cfgChangeEn,
  input  logic            modeWrEn,
  input  logic            modeWrVal,
  input  logic            storeReq,
  input  logic            storeAbort,
  input  logic            ackWrEn,
  input  logic [IDXW-1:0] ackIdx,
  input  logic            clrNew,
  input  logic            clrFull,
  input  logic            clrLost,
  output logic [IDXW-1:0] putIdx,
  output logic [IDXW-1:0] getIdx,
  output logic [CNTW-1:0] fillLevel,
  output logic            fullSt,
  output logic            lostSt,
  output logic            irqNew,
  output logic            irqFull,
  output logic            irqLost,
  output logic            modeOverwrite
);
  rxqStrobeT       strb;
  logic [IDXW-1:0] getTarget;
  logic [CNTW-1:0] relCnt;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .cfgInit      (cfgInit),
    .cfgChangeEn  (cfgChangeEn),
    .modeWrEn     (modeWrEn),
    .storeReq     (storeReq),
    .storeAbort   (storeAbort),
    .ackWrEn      (ackWrEn),
    .ackIdx       (ackIdx),
    .getIdx       (getIdx),
    .fillLevel    (fillLevel),
    .modeOverwrite(modeOverwrite),
    .strb         (strb),
    .getTarget    (getTarget),
    .relCnt       (relCnt)
  );

  rxq_dp #(.DEPTH(DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .getTarget    (getTarget),
    .relCnt       (relCnt),
    .modeWrVal    (modeWrVal),
    .clrNew       (clrNew),
    .clrFull      (clrFull),
    .clrLost      (clrLost),
    .putIdx       (putIdx),
    .getIdx       (getIdx),
    .fillLevel    (fillLevel),
    .irqNew       (irqNew),
    .irqFull      (irqFull),
    .irqLost      (irqLost),
    .modeOverwrite(modeOverwrite)
  );

  assign fullSt = (fillLevel == CNTW'(DEPTH));
  assign lostSt = irqLost;
endmodule

// File: rtl/rxq_index_mgr_chk.sv
module rxq_index_mgr_chk #(
  parameter int DEPTH = 3,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            cfgInit,
  input logic            cfgChangeEn,
  input logic            storeReq,
  input logic            storeAbort,
  input logic            ackWrEn,
  input logic [IDXW-1:0] ackIdx,
  input logic [IDXW-1:0] putIdx,
  input logic [IDXW-1:0] getIdx,
  input logic [CNTW-1:0] fillLevel,
  input logic            fullSt,
  input logic            irqLost,
  input logic            modeOverwrite
);
  logic [IDXW:0] ptrDiff;
  always_comb begin
    if ({1'b0, putIdx} >= {1'b0, getIdx})
      ptrDiff = {1'b0, putIdx} - {1'b0, getIdx};
    else
      ptrDiff = {1'b0, putIdx} + (IDXW + 1)'(DEPTH) - {1'b0, getIdx};
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (int'(putIdx) < DEPTH) && (int'(getIdx) < DEPTH) && (int'(fillLevel) <= DEPTH)); // R2

  AST_PTR_CONSISTENT: assert property (@(posedge clk) disable iff (!rstN)
    ((fillLevel == '0) || (int'(fillLevel) == DEPTH)) ? (putIdx == getIdx)
                                                      : (int'(ptrDiff) == int'(fillLevel))); // R3

  AST_BAD_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ackWrEn && (int'(ackIdx) >= DEPTH) && !storeReq)
      |=> ($stable(getIdx) && $stable(fillLevel))); // R4

  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq && !storeAbort && fullSt && !modeOverwrite && !ackWrEn)
      |=> ($stable(putIdx) && $stable(getIdx) && $stable(fillLevel) && irqLost)); // R6

  AST_OVR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq && !storeAbort && fullSt && modeOverwrite && !ackWrEn)
      |=> ((int'(fillLevel) == DEPTH) && (putIdx != $past(putIdx))
           && (getIdx != $past(getIdx)))); // R7

  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgInit && cfgChangeEn) |=> $stable(modeOverwrite)); // R8

  AST_ABORT_NOPUT: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq && storeAbort && !ackWrEn)
      |=> ($stable(putIdx) && $stable(fillLevel) && $stable(getIdx))); // R9
endmodule

bind rxq_index_mgr rxq_index_mgr_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgInit      (cfgInit),
  .cfgChangeEn  (cfgChangeEn),
  .storeReq     (storeReq),
  .storeAbort   (storeAbort),
  .ackWrEn      (ackWrEn),
  .ackIdx       (ackIdx),
  .putIdx       (putIdx),
  .getIdx       (getIdx),
  .fillLevel    (fillLevel),
  .fullSt       (fullSt),
  .irqLost      (irqLost),
  .modeOverwrite(modeOverwrite)
);

// File: tb/rxq_index_mgr_bench.sv
module rxq_index_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgInit = 1'b0, cfgChangeEn = 1'b0, modeWrEn = 1'b0, modeWrVal = 1'b0;
  logic       storeReq = 1'b0, storeAbort = 1'b0, ackWrEn = 1'b0;
  logic [1:0] ackIdx = 2'd0;
  logic       clrNew = 1'b0, clrFull = 1'b0, clrLost = 1'b0;
  logic [1:0] putIdx, getIdx, fillLevel;
  logic       fullSt, lostSt, irqNew, irqFull, irqLost, modeOverwrite;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxq_index_mgr u_rxq_index_mgr (
    .clk(clk), .rstN(rstN), .cfgInit(cfgInit), .cfgChangeEn(cfgChangeEn),
    .modeWrEn(modeWrEn), .modeWrVal(modeWrVal), .storeReq(storeReq),
    .storeAbort(storeAbort), .ackWrEn(ackWrEn), .ackIdx(ackIdx),
    .clrNew(clrNew), .clrFull(clrFull), .clrLost(clrLost),
    .putIdx(putIdx), .getIdx(getIdx), .fillLevel(fillLevel), .fullSt(fullSt),
    .lostSt(lostSt), .irqNew(irqNew), .irqFull(irqFull), .irqLost(irqLost),
    .modeOverwrite(modeOverwrite)
  );

  // Vector: store, abort, ack, ackIdx[2], clr{new,full,lost}, then the
  // expected put[2], get[2], fill[2], flags{new,full,lost}. Hold-off mode.
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1,1'b0,1'b0,2'd0,3'b000, 2'd1,2'd0,2'd1,3'b100},  // 0 R2 first store
    {1'b1,1'b0,1'b0,2'd0,3'b000, 2'd2,2'd0,2'd2,3'b100},  // 1 R2
    {1'b1,1'b0,1'b0,2'd0,3'b000, 2'd0,2'd0,2'd3,3'b110},  // 2 R2 wrap, R5 full
    {1'b1,1'b0,1'b0,2'd0,3'b000, 2'd0,2'd0,2'd3,3'b111},  // 3 R6 dropped
    {1'b0,1'b0,1'b0,2'd0,3'b111, 2'd0,2'd0,2'd3,3'b000},  // 4 R10 clear all
    {1'b0,1'b0,1'b1,2'd0,3'b000, 2'd0,2'd1,2'd2,3'b000},  // 5 R3 release one
    {1'b0,1'b0,1'b1,2'd0,3'b000, 2'd0,2'd1,2'd2,3'b000},  // 6 R4 unoccupied
    {1'b0,1'b0,1'b1,2'd3,3'b000, 2'd0,2'd1,2'd2,3'b000},  // 7 R4 out of range
    {1'b0,1'b0,1'b1,2'd2,3'b000, 2'd0,2'd0,2'd0,3'b000},  // 8 R3 release two
    {1'b1,1'b0,1'b0,2'd0,3'b000, 2'd1,2'd0,2'd1,3'b100},  // 9 R2
    {1'b1,1'b0,1'b1,2'd0,3'b000, 2'd2,2'd1,2'd1,3'b100},  // 10 R11 store+ack
    {1'b1,1'b1,1'b0,2'd0,3'b000, 2'd2,2'd1,2'd1,3'b100},  // 11 R9 aborted
    {1'b1,1'b0,1'b0,2'd0,3'b100, 2'd0,2'd1,2'd2,3'b100}   // 12 R10 set wins
  };
  localparam string VTAG [NVEC] = '{"R2","R2","R5","R6","R10","R3","R4",
                                    "R4","R3","R2","R11","R9","R10"};

  task automatic checkState(input string tag, input logic [1:0] ePut,
                            input logic [1:0] eGet, input logic [1:0] eFill,
                            input logic [2:0] eFlags, input logic eMode);
    logic [11:0] act, exp;
    act = {putIdx, getIdx, fillLevel, irqNew, irqFull, irqLost, lostSt, fullSt, modeOverwrite};
    exp = {ePut, eGet, eFill, eFlags, eFlags[0], (eFill == 2'd3), eMode};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: put/get/fill/new/full/lost/lostSt/fullSt/mode actual %b expected %b",
               tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    storeReq = 1'b0; storeAbort = 1'b0; ackWrEn = 1'b0; ackIdx = 2'd0;
    clrNew = 1'b0; clrFull = 1'b0; clrLost = 1'b0; modeWrEn = 1'b0;
    cfgInit = 1'b0; cfgChangeEn = 1'b0; modeWrVal = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkState("R1 reset state", 2'd0, 2'd0, 2'd0, 3'b000, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      storeReq   = VEC[i][16];
      storeAbort = VEC[i][15];
      ackWrEn    = VEC[i][14];
      ackIdx     = VEC[i][13:12];
      {clrNew, clrFull, clrLost} = VEC[i][11:9];
      tick();
      idleInputs();
      checkState(VTAG[i], VEC[i][8:7], VEC[i][6:5], VEC[i][4:3], VEC[i][2:0], 1'b0);
    end
    // Now: put0 get1 fill2, new set.

    // R8: mode write with only one of the two enables is ignored.
    modeWrEn = 1'b1; modeWrVal = 1'b1; cfgInit = 1'b1; cfgChangeEn = 1'b0;
    tick(); idleInputs();
    checkState("R8 locked (init only)", 2'd0, 2'd1, 2'd2, 3'b100, 1'b0);
    modeWrEn = 1'b1; modeWrVal = 1'b1; cfgInit = 1'b0; cfgChangeEn = 1'b1;
    tick(); idleInputs();
    checkState("R8 locked (change only)", 2'd0, 2'd1, 2'd2, 3'b100, 1'b0);
    modeWrEn = 1'b1; modeWrVal = 1'b1; cfgInit = 1'b1; cfgChangeEn = 1'b1;
    tick(); idleInputs();
    checkState("R8 unlocked write", 2'd0, 2'd1, 2'd2, 3'b100, 1'b1);

    // R5: fill to three in replace mode.
    storeReq = 1'b1; tick(); idleInputs();
    checkState("R5 becomes full", 2'd1, 2'd1, 2'd3, 3'b110, 1'b1);

    // R7: replacing store on a full queue.
    storeReq = 1'b1; tick(); idleInputs();
    checkState("R7 replace oldest", 2'd2, 2'd2, 2'd3, 3'b110, 1'b1);

    // R11: full queue, ack of slot 2 (one slot) and store together.
    storeReq = 1'b1; ackWrEn = 1'b1; ackIdx = 2'd2; tick(); idleInputs();
    checkState("R11 ack before store", 2'd0, 2'd0, 2'd3, 3'b110, 1'b1);

    // R1: reset in mid-run restores all state and the mode.
    rstN = 1'b0; tick(); rstN = 1'b1;
    checkState("R1 reset mid-run", 2'd0, 2'd0, 2'd0, 3'b000, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule